// File: doc/BRIEF.md
# Machine-Mode Address Breakpoint Trigger Bank

This block holds a small set of address-match breakpoint triggers for a 64-bit hart. Software reaches it through three CSR-style registers. The first picks which trigger is visible. The second holds that trigger's arm bits. The third holds that trigger's 64-bit compare address. Every trigger watches the same per-cycle access port, which carries a valid flag, the kind of access (instruction fetch, data load or data store), the access address and the PC of the instruction that made it.

A trigger can be armed for any mix of fetch, load and store matching, gated by a machine-mode enable. It fires when a valid access of an armed kind hits its stored address exactly while the hart runs in machine mode. A hit raises a breakpoint request with cause code 3 and the faulting PC. The request also drives a kill signal in the same cycle, so the pipeline can drop the access and its side effect, for example a store that would otherwise reach memory. All triggers are live at once. When several match in one cycle, a single hit is reported.

The control register is write-any, read-legal. Its top nibble always reads as the address-match type code 2, and only the supported arm bits keep what was written. Software can therefore probe which settings exist. The select register accepts only indices of triggers that exist, so probing it reveals how many triggers are present.

Top module: `dbg_addr_trigger`

## Requirements
- R1: After reset the select register reads 0, every trigger's arm bits and compare address are 0, and no access produces a hit.
- R2: A write to the select register (csr_sel = 0) with a value below NUM_TRIG is stored and reads back unchanged. A larger value is ignored, so the previous index reads back.
- R3: The control register (csr_sel = 1) always reads bits 63:60 as 2 and bits 59:11 as 0, whatever was written.
- R4: In the control register, bit 6 is the machine-mode enable, bit 2 is execute, bit 1 is store and bit 0 is load. These four bits read back as written. Every other bit of 10:0 reads 0.
- R5: The match-address register (csr_sel = 2) of the selected trigger stores all 64 written bits and reads them back.
- R6: An execute-armed trigger hits only on a fetch (acc_kind = 0) whose address equals the stored address in all 64 bits. A load or store to that address, or a fetch to any other address, does not hit.
- R7: A load-armed trigger hits on a load (acc_kind = 1) from the stored address. A store (acc_kind = 2) to the same address does not hit.
- R8: A store-armed trigger hits on a matching store, and acc_suppress is high in that same cycle.
- R9: During a hit, exc_cause is 3 and exc_epc equals acc_pc. Without a hit, bp_hit, acc_suppress, exc_cause and exc_epc are all 0.
- R10: No hit occurs while priv_m is low, while acc_valid is low, or when the trigger's machine-mode enable bit is clear.
- R11: Triggers match independently at the same time. Writing the select register, or writing another trigger's registers, leaves a trigger's configuration unchanged.
- R12: When more than one trigger matches in a cycle, exactly one hit is reported, with cause 3 and the access PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register choice: 0 select, 1 control, 2 match address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data of the chosen register (combinational) |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store |
| acc_addr | input | XLEN | Access address |
| acc_pc | input | XLEN | PC of the instruction making the access |
| priv_m | input | 1 | Hart is in machine mode |
| bp_hit | output | 1 | Breakpoint request |
| exc_cause | output | XLEN | Exception cause, 3 on a hit |
| exc_epc | output | XLEN | Exception PC, the access PC on a hit |
| acc_suppress | output | 1 | Kill the current access |

## Verification
The embedded properties check on every cycle that the select index stays within the bank, that a trigger not being written keeps its arm bits and address, and that at most one grant is raised. They also check that a hit only appears with a valid machine-mode access and always carries cause 3, the access PC and a kill. Whether the right access kind and the exact address fire the right trigger only shows in the bench's scenarios. The same holds for the legal-value read-back of the control and select registers and for two triggers coexisting through select rewrites.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        REG_SELECT = 2'd0,
        REG_CTRL   = 2'd1,
        REG_MATCH  = 2'd2
    } csr_reg_e;

    // Control register layout (software decodes these positions)
    localparam int BIT_MMODE = 6;
    localparam int BIT_EXEC  = 2;
    localparam int BIT_STORE = 1;
    localparam int BIT_LOAD  = 0;
    localparam int LOW_W     = 11;
    localparam int TYPE_W    = 4;

    localparam logic [TYPE_W-1:0] TRIG_TYPE_ADDR = 4'd2;
    localparam int CAUSE_BREAKPOINT = 3;

    typedef struct packed {
        logic mmode;
        logic exec;
        logic store;
        logic load;
    } arm_t;

endpackage

// File: rtl/dbg_trig_slot.sv
module dbg_trig_slot
    import dbg_trig_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ctrl,
    input  logic            wr_addr,
    input  logic [XLEN-1:0] wdata,
    input  logic            acc_valid,
    input  logic [1:0]      acc_kind,
    input  logic [XLEN-1:0] acc_addr,
    input  logic            priv_m,
    output arm_t            arm_q,
    output logic [XLEN-1:0] match_q,
    output logic            hit
);

    logic kind_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q   <= '0;
            match_q <= '0;
        end else begin
            if (wr_ctrl) begin
                arm_q.mmode <= wdata[BIT_MMODE];
                arm_q.exec  <= wdata[BIT_EXEC];
                arm_q.store <= wdata[BIT_STORE];
                arm_q.load  <= wdata[BIT_LOAD];
            end
            if (wr_addr) begin
                match_q <= wdata;
            end
        end
    end

    always_comb begin
        unique case (acc_kind)
            ACC_FETCH: kind_ok = arm_q.exec;
            ACC_LOAD:  kind_ok = arm_q.load;
            ACC_STORE: kind_ok = arm_q.store;
            default:   kind_ok = 1'b0;
        endcase
    end

    assign hit = acc_valid && priv_m && arm_q.mmode && kind_ok
                 && (acc_addr == match_q);

    // R11: configuration is held unless this slot is written
    assert_arm_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(arm_q));
    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_addr |=> $stable(match_q));

endmodule

// File: rtl/dbg_trig_arbiter.sv
module dbg_trig_arbiter #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hits,
    output logic [N-1:0] grant,
    output logic         any
);

    logic seen;

    always_comb begin
        seen = 1'b0;
        for (int i = 0; i < N; i++) begin
            grant[i] = hits[i] && !seen;
            seen     = seen || hits[i];
        end
    end

    assign any = |grant;

    // R12: a single trigger is reported per cycle
    assert_single_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_covers_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|hits) |-> any);

endmodule

// File: rtl/dbg_addr_trigger.sv
module dbg_addr_trigger
    import dbg_trig_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int NUM_TRIG = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [1:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            acc_valid,
    input  logic [1:0]      acc_kind,
    input  logic [XLEN-1:0] acc_addr,
    input  logic [XLEN-1:0] acc_pc,
    input  logic            priv_m,
    output logic            bp_hit,
    output logic [XLEN-1:0] exc_cause,
    output logic [XLEN-1:0] exc_epc,
    output logic            acc_suppress
);

    localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
    localparam int MID_W = XLEN - TYPE_W - LOW_W;

    logic [SEL_W-1:0]  sel_q;
    logic [NUM_TRIG-1:0] hits;
    logic [NUM_TRIG-1:0] grant;
    logic              any_hit;
    arm_t              arm_all  [NUM_TRIG];
    logic [XLEN-1:0]   addr_all [NUM_TRIG];
    arm_t              arm_cur;
    logic [LOW_W-1:0]  low_bits;
    logic              sel_legal;

    assign sel_legal = (csr_wdata < XLEN'(NUM_TRIG));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (csr_we && (csr_sel == REG_SELECT) && sel_legal) begin
            sel_q <= csr_wdata[SEL_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
        logic wr_c;
        logic wr_a;
        assign wr_c = csr_we && (csr_sel == REG_CTRL)  && (sel_q == SEL_W'(g));
        assign wr_a = csr_we && (csr_sel == REG_MATCH) && (sel_q == SEL_W'(g));

        dbg_trig_slot #(.XLEN(XLEN)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctrl   (wr_c),
            .wr_addr   (wr_a),
            .wdata     (csr_wdata),
            .acc_valid (acc_valid),
            .acc_kind  (acc_kind),
            .acc_addr  (acc_addr),
            .priv_m    (priv_m),
            .arm_q     (arm_all[g]),
            .match_q   (addr_all[g]),
            .hit       (hits[g])
        );
    end

    dbg_trig_arbiter #(.N(NUM_TRIG)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .hits  (hits),
        .grant (grant),
        .any   (any_hit)
    );

    assign arm_cur = arm_all[sel_q];

    always_comb begin
        low_bits            = '0;
        low_bits[BIT_MMODE] = arm_cur.mmode;
        low_bits[BIT_EXEC]  = arm_cur.exec;
        low_bits[BIT_STORE] = arm_cur.store;
        low_bits[BIT_LOAD]  = arm_cur.load;
    end

    always_comb begin
        unique case (csr_sel)
            REG_SELECT: csr_rdata = XLEN'(sel_q);
            REG_CTRL:   csr_rdata = {TRIG_TYPE_ADDR, {MID_W{1'b0}}, low_bits};
            REG_MATCH:  csr_rdata = addr_all[sel_q];
            default:    csr_rdata = '0;
        endcase
    end

    assign bp_hit       = any_hit;
    assign acc_suppress = any_hit;
    assign exc_cause    = any_hit ? XLEN'(CAUSE_BREAKPOINT) : '0;
    assign exc_epc      = any_hit ? acc_pc : '0;

    // R2: the select index never leaves the bank
    assert_sel_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sel_q) < NUM_TRIG);
    // R10: a hit needs a valid machine-mode access
    assert_hit_mmode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit |-> (acc_valid && priv_m));
    // R9: a hit carries the breakpoint cause and the access PC
    assert_hit_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit |-> (exc_cause == XLEN'(CAUSE_BREAKPOINT) && exc_epc == acc_pc));
    // R8: a hit always kills the access
    assert_store_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_hit && acc_kind == ACC_STORE) |-> acc_suppress);

endmodule

// File: tb/dbg_addr_trigger_bench.sv
module dbg_addr_trigger_bench;

    localparam int XLEN = 64;
    localparam logic [63:0] A0 = 64'h0000_0000_8000_1000;
    localparam logic [63:0] A1 = 64'h0000_0000_8000_2000;
    localparam logic [63:0] TYPE_ONLY = 64'h2000_0000_0000_0000;
    localparam logic [63:0] PC_BASE = 64'h0000_0000_8000_0100;

    typedef struct packed {
        logic [1:0]  kind;
        logic        priv;
        logic [63:0] addr;
        logic        exp;
    } vec_t;

    // slot0: M|EXEC at A0, slot1: M|LOAD at A1
    localparam vec_t VECS [10] = '{
        '{2'd0, 1'b1, A0,                 1'b1},  // R6 fetch hit
        '{2'd1, 1'b1, A0,                 1'b0},  // R6 load same addr
        '{2'd2, 1'b1, A0,                 1'b0},  // R6 store same addr
        '{2'd0, 1'b1, A0 + 64'd4,         1'b0},  // R6 neighbour addr
        '{2'd0, 1'b1, A0 ^ (64'd1 << 63), 1'b0},  // R6 top bit differs
        '{2'd1, 1'b1, A1,                 1'b1},  // R7 load hit
        '{2'd2, 1'b1, A1,                 1'b0},  // R7 store no hit
        '{2'd0, 1'b1, A1,                 1'b0},  // R7 fetch no hit
        '{2'd0, 1'b0, A0,                 1'b0},  // R10 not machine mode
        '{2'd1, 1'b0, A1,                 1'b0}   // R10 not machine mode
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_we = 1'b0;
    logic [1:0]      csr_sel = 2'd0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            acc_valid = 1'b0;
    logic [1:0]      acc_kind = 2'd0;
    logic [XLEN-1:0] acc_addr = '0;
    logic [XLEN-1:0] acc_pc = '0;
    logic            priv_m = 1'b0;
    logic            bp_hit;
    logic [XLEN-1:0] exc_cause;
    logic [XLEN-1:0] exc_epc;
    logic            acc_suppress;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    dbg_addr_trigger #(.XLEN(XLEN), .NUM_TRIG(2)) u_dbg_addr_trigger (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .acc_valid(acc_valid),
        .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_pc(acc_pc),
        .priv_m(priv_m), .bp_hit(bp_hit), .exc_cause(exc_cause),
        .exc_epc(exc_epc), .acc_suppress(acc_suppress)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [1:0] sel, input logic [63:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [1:0] sel, output logic [63:0] d);
        @(negedge clk);
        csr_sel = sel;
        #1;
        d = csr_rdata;
    endtask

    // Present one access and check all hit outputs against exp
    task automatic access(input string req, input logic [1:0] kind, input logic pm,
                          input logic [63:0] addr, input logic [63:0] pc,
                          input logic valid, input logic exp);
        @(negedge clk);
        acc_valid = valid; acc_kind = kind; priv_m = pm; acc_addr = addr; acc_pc = pc;
        #1;
        chk(req, {63'd0, bp_hit}, {63'd0, exp});
        chk(req, {63'd0, acc_suppress}, {63'd0, exp});
        chk(req, exc_cause, exp ? 64'd3 : 64'd0);
        chk(req, exc_epc, exp ? pc : 64'd0);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] r;
        do_reset();

        // R1 reset state
        csr_rd(2'd0, r); chk("R1 select", r, 64'd0);
        csr_rd(2'd1, r); chk("R1 ctrl", r, TYPE_ONLY);
        csr_rd(2'd2, r); chk("R1 addr", r, 64'd0);
        access("R1 no hit", 2'd0, 1'b1, 64'd0, PC_BASE, 1'b1, 1'b0);

        // configure both triggers (R11: select rewrites between)
        csr_wr(2'd0, 64'd0);
        csr_wr(2'd1, 64'h44);
        csr_wr(2'd2, A0);
        csr_wr(2'd0, 64'd1);
        csr_wr(2'd1, 64'h41);
        csr_wr(2'd2, A1);
        csr_rd(2'd2, r); chk("R5 addr slot1", r, A1);
        csr_wr(2'd0, 64'd0);
        csr_rd(2'd1, r); chk("R11 slot0 ctrl kept", r, TYPE_ONLY | 64'h44);
        csr_rd(2'd2, r); chk("R11 slot0 addr kept", r, A0);

        for (int i = 0; i < 10; i++) begin
            access("R6/R7/R10 table", VECS[i].kind, VECS[i].priv, VECS[i].addr,
                   PC_BASE + 64'(i * 4), 1'b1, VECS[i].exp);
        end

        // R10 valid low
        access("R10 valid low", 2'd0, 1'b1, A0, PC_BASE, 1'b0, 1'b0);

        // R2 select legality
        csr_wr(2'd0, 64'd1);
        csr_rd(2'd0, r); chk("R2 sel 1", r, 64'd1);
        csr_wr(2'd0, 64'd5);
        csr_rd(2'd0, r); chk("R2 sel 5 ignored", r, 64'd1);
        csr_wr(2'd0, 64'h8000_0000_0000_0000);
        csr_rd(2'd0, r); chk("R2 sel huge ignored", r, 64'd1);
        csr_wr(2'd0, 64'd0);
        csr_rd(2'd0, r); chk("R2 sel 0", r, 64'd0);

        // R8 store trigger on slot0
        csr_wr(2'd1, 64'h42);
        access("R8 store hit", 2'd2, 1'b1, A0, PC_BASE + 64'h40, 1'b1, 1'b1);
        access("R8 load no hit", 2'd1, 1'b1, A0, PC_BASE, 1'b1, 1'b0);
        // R11 slot1 still load-armed
        access("R11 slot1 still fires", 2'd1, 1'b1, A1, PC_BASE + 64'h44, 1'b1, 1'b1);

        // R12 both triggers on the same load address
        csr_wr(2'd1, 64'h41);
        csr_wr(2'd2, A1);
        access("R12 double match", 2'd1, 1'b1, A1, PC_BASE + 64'h48, 1'b1, 1'b1);

        // R3/R4 legal read-back
        csr_wr(2'd1, 64'h4C);
        csr_rd(2'd1, r); chk("R4 unsupported bit dropped", r, TYPE_ONLY | 64'h44);
        csr_wr(2'd1, 64'hF000_0000_0000_07FF);
        csr_rd(2'd1, r); chk("R3 type fixed", r, TYPE_ONLY | 64'h47);
        csr_wr(2'd1, 64'h0FFF_FFFF_FFFF_F800);
        csr_rd(2'd1, r); chk("R3 middle zero", r, TYPE_ONLY);

        // R10 machine-mode enable clear
        csr_wr(2'd1, 64'h04);
        csr_wr(2'd2, A0);
        access("R10 mmode bit clear", 2'd0, 1'b1, A0, PC_BASE, 1'b1, 1'b0);

        // R5 full-width address
        csr_wr(2'd2, 64'hDEAD_BEEF_0123_4567);
        csr_rd(2'd2, r); chk("R5 addr 64 bits", r, 64'hDEAD_BEEF_0123_4567);

        // R1 reset clears everything again
        do_reset();
        csr_rd(2'd0, r); chk("R1 select after reset", r, 64'd0);
        csr_rd(2'd1, r); chk("R1 ctrl after reset", r, TYPE_ONLY);
        access("R1 slot1 disarmed", 2'd1, 1'b1, A1, PC_BASE, 1'b1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule